// File: doc/BRIEF.md
# Reloadable PWM Timer with Triggered Pin Override

A 16-bit up-counting timer that drives one output pin with either a pulse-width-modulated waveform or a square wave. Software reaches the block through a narrow write port with three registers: a period buffer, a duty buffer and a control word. Period and duty values are double-buffered. A new value waits in its buffer and moves to the active compare stage only when the count wraps back to zero. Software can therefore change both cycle length and duty on a running waveform without ever producing a truncated or stretched pulse. A count-enable input supplies the timebase, so an external divider can set the tick rate.

An input-capture channel samples the count when a synchronized edge of the polarity chosen in the control word appears on the capture input. A second input, the trigger, lets hardware take over the pin at once. When the selected trigger edge arrives and an override state is armed in the control word, the pin is forced high, forced low or released to high impedance. It stays that way until software writes the control word with the override field set to none. Two single-cycle interrupt pulses mark the period wrap and the duty match.

Top module: `tmr_rtpwm`

## Requirements
- R1: After reset, count, cap_value, irq_period and irq_duty are 0, pin_oe is 1 and pin_out is 0. The reset values are period buffer 0xFFFF, duty buffer 0 and control 0.
- R2: The count rises by one on each clock where the run bit (control bit 0) is 1 and cnt_en is 1. On every other clock it holds its value.
- R3: On a counting clock where the count is greater than or equal to the active period, the count goes to 0 instead of rising. irq_period is 1 for exactly the cycle that follows each such wrap.
- R4: Writes to address 0 (period) and address 1 (duty) land in buffers. While running, the active values take the buffered values only at a wrap. While stopped, the active values copy the buffers one clock after each write.
- R5: With control bit 1 at 0 (PWM mode) and no override in force, pin_out is 1 exactly when count is below the active duty, and pin_oe is 1.
- R6: With control bit 1 at 1 (square mode) and no override in force, pin_out toggles once per wrap.
- R7: irq_duty is 1 for one cycle after each counting clock whose new count equals the active duty value in effect after that clock.
- R8: Control bits 3:2 select the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge on cap_in loads count into cap_value on the third rising clock edge after the input change. An edge that is not selected leaves cap_value unchanged.
- R9: Control bits 6:5 arm the override: 01 high, 10 low, 11 high impedance (pin_oe 0, pin_out 0). A selected trigger edge with a nonzero field starts the override on the third clock edge after the change. Once in force, the pin follows the current field value.
- R10: A control write with bits 6:5 at 00 ends the override, and the waveform returns on the next cycle.
- R11: Control bit 4 picks the trigger polarity (0 rising, 1 falling). A trigger edge of the other polarity, or any trigger edge while the field is 00, has no effect, including after a later write that arms the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 duty, 2 control |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Count tick enable |
| cap_in | input | 1 | Capture input (asynchronous) |
| trig_in | input | 1 | Override trigger input (asynchronous) |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| irq_period | output | 1 | Wrap interrupt pulse |
| irq_duty | output | 1 | Duty match interrupt pulse |
| count | output | 16 | Current count |
| cap_value | output | 16 | Last captured count |

## Verification
The assertions check on every cycle that the count holds without a tick and clears after a wrap, and that the wrap pulse coincides with a zero count. They also check that active compare values move only at a wrap while running, that the PWM level matches the count-versus-duty relation, that high impedance always drives a low value, and that a clearing write releases the pin. The bench's scenarios show the properties that depend on history: the exact cycle at which a reload takes effect in a running waveform, the capture and override latency through the synchronizers, the rejection of wrong-polarity or disarmed edges, and the square-wave phase over many randomized periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] A_DUTY   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  typedef enum logic [1:0] {
    OVR_NONE = 2'b00,
    OVR_HIGH = 2'b01,
    OVR_LOW  = 2'b10,
    OVR_HIZ  = 2'b11
  } ovr_sel_e;

  typedef struct packed {
    ovr_sel_e   ovr;
    logic       trig_fall;
    logic [1:0] cap_edge;
    logic       mode_sq;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick_en,
  input  logic         mode_sq,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  output logic [W-1:0] count,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act,
  output logic         wave,
  output logic         irq_period,
  output logic         irq_duty
);
  logic [W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  logic         pwm_q, pwm_d, sq_q, sq_d, irqp_d, irqd_d;
  logic         irqp_q, irqd_q, tick, wrap;

  always_comb begin
    tick   = run & tick_en;
    wrap   = tick && (cnt_q >= per_q);
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    sq_d   = sq_q;
    if (!run) begin
      per_d  = per_buf;
      duty_d = duty_buf;
    end else if (wrap) begin
      cnt_d  = '0;
      per_d  = per_buf;
      duty_d = duty_buf;
      sq_d   = ~sq_q;
    end else if (tick) begin
      cnt_d  = cnt_q + 1'b1;
    end
    pwm_d  = (cnt_d < duty_d);
    irqp_d = wrap;
    irqd_d = tick && (cnt_d == duty_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '1;
      duty_q <= '0;
      pwm_q  <= 1'b0;
      sq_q   <= 1'b0;
      irqp_q <= 1'b0;
      irqd_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      pwm_q  <= pwm_d;
      sq_q   <= sq_d;
      irqp_q <= irqp_d;
      irqd_q <= irqd_d;
    end
  end

  assign count      = cnt_q;
  assign per_act    = per_q;
  assign duty_act   = duty_q;
  assign wave       = mode_sq ? sq_q : pwm_q;
  assign irq_period = irqp_q;
  assign irq_duty   = irqd_q;
endmodule

// File: rtl/tmr_pinctl.sv
module tmr_pinctl
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ovr_sel_e sel,
  input  logic     trig_hit,
  input  logic     clr,
  input  logic     wave,
  output logic     pin_out,
  output logic     pin_oe,
  output logic     ovr_active
);
  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (clr)                              act_d = 1'b0;
    else if (trig_hit && sel != OVR_NONE) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  always_comb begin
    pin_out = wave;
    pin_oe  = 1'b1;
    if (act_q) begin
      unique case (sel)
        OVR_HIGH: pin_out = 1'b1;
        OVR_LOW:  pin_out = 1'b0;
        OVR_HIZ:  begin pin_out = 1'b0; pin_oe = 1'b0; end
        default:  pin_out = wave;
      endcase
    end
  end

  assign ovr_active = act_q;
endmodule

// File: rtl/tmr_rtpwm.sv
module tmr_rtpwm
  import tmr_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              cnt_en,
  input  logic              cap_in,
  input  logic              trig_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_period,
  output logic              irq_duty,
  output logic [W-1:0]      count,
  output logic [W-1:0]      cap_value
);
  logic [1:0]   rst_pipe;
  logic         rst_s;
  logic [W-1:0] per_buf_q, duty_buf_q, cap_q;
  ctrl_t        ctrl_q, ctrl_wr;
  logic         cap_rise, cap_fall, trg_rise, trg_fall, cap_hit, trig_hit, clr;
  logic         wave, ovr_active, run_w, mode_w;
  logic [W-1:0] per_act, duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign ctrl_wr  = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign clr      = wr_en && (wr_addr == A_CTRL) && (ctrl_wr.ovr == OVR_NONE);
  assign cap_hit  = (ctrl_q.cap_edge[0] & cap_rise) | (ctrl_q.cap_edge[1] & cap_fall);
  assign trig_hit = ctrl_q.trig_fall ? trg_fall : trg_rise;
  assign run_w    = ctrl_q.run;
  assign mode_w   = ctrl_q.mode_sq;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      per_buf_q  <= '1;
      duty_buf_q <= '0;
      ctrl_q     <= '0;
      cap_q      <= '0;
    end else begin
      if (wr_en && wr_addr == A_PERIOD) per_buf_q  <= wr_data;
      if (wr_en && wr_addr == A_DUTY)   duty_buf_q <= wr_data;
      if (wr_en && wr_addr == A_CTRL)   ctrl_q     <= ctrl_wr;
      if (cap_hit)                      cap_q      <= count;
    end
  end

  tmr_sync_edge #(.STAGES(SYNC_LEN)) u_cap_sync (
    .clk(clk), .rst_n(rst_s), .async_in(cap_in), .rise(cap_rise), .fall(cap_fall));

  tmr_sync_edge #(.STAGES(SYNC_LEN)) u_trg_sync (
    .clk(clk), .rst_n(rst_s), .async_in(trig_in), .rise(trg_rise), .fall(trg_fall));

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_s), .run(run_w), .tick_en(cnt_en), .mode_sq(mode_w),
    .per_buf(per_buf_q), .duty_buf(duty_buf_q), .count(count), .per_act(per_act),
    .duty_act(duty_act), .wave(wave), .irq_period(irq_period), .irq_duty(irq_duty));

  tmr_pinctl u_pin (
    .clk(clk), .rst_n(rst_s), .sel(ctrl_q.ovr), .trig_hit(trig_hit), .clr(clr),
    .wave(wave), .pin_out(pin_out), .pin_oe(pin_oe), .ovr_active(ovr_active));

  assign cap_value = cap_q;
endmodule

// File: rtl/tmr_rtpwm_chk.sv
module tmr_rtpwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick_en,
  input logic         mode_sq,
  input logic         ovr_active,
  input logic         clr,
  input logic [W-1:0] count,
  input logic [W-1:0] per_act,
  input logic [W-1:0] duty_act,
  input logic         irq_period,
  input logic         pin_out,
  input logic         pin_oe
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !tick_en) |=> $stable(count)); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && count >= per_act) |=> (count == '0)); // R3

  AST_WRAP_IRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> (count == '0)); // R3

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick_en && count >= per_act)) |=> ($stable(per_act) && $stable(duty_act))); // R4

  AST_PWM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sq && !ovr_active) |-> (pin_oe && (pin_out == (count < duty_act)))); // R5

  AST_HIZ_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out); // R9

  AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pin_oe && !ovr_active)); // R10
endmodule

bind tmr_rtpwm tmr_rtpwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_s), .run(run_w), .tick_en(cnt_en), .mode_sq(mode_w),
  .ovr_active(ovr_active), .clr(clr), .count(count), .per_act(per_act),
  .duty_act(duty_act), .irq_period(irq_period), .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/sim_tmr_rtpwm.sv
module sim_tmr_rtpwm;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic cnt_en = 1'b0, cap_in = 1'b0, trig_in = 1'b0;
  logic pin_out, pin_oe, irq_period, irq_duty;
  logic [W-1:0] count, cap_value;

  int n_chk = 0, n_fail = 0;
  bit chk_wave = 1'b0;

  // reference model state
  logic [W-1:0] m_cnt = '0, m_per = '1, m_dut = '0, b_per = '1, b_dut = '0;
  logic m_run = 1'b0, m_mode = 1'b0, m_sq = 1'b0, m_irqp = 1'b0, m_irqd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_rtpwm #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_en(cnt_en), .cap_in(cap_in), .trig_in(trig_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_period(irq_period), .irq_duty(irq_duty),
    .count(count), .cap_value(cap_value));

  function automatic logic [W-1:0] ctrl_word(bit run, bit sq, bit [1:0] cap, bit tf, bit [1:0] sel);
    return W'({sel, tf, cap, sq, run});
  endfunction

  function automatic logic exp_wave();
    return m_mode ? m_sq : (m_cnt < m_dut);
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven; update model, then check away from the edge
  task automatic cyc();
    bit tick, wrap;
    @(posedge clk);
    tick = m_run && cnt_en;
    wrap = tick && (m_cnt >= m_per);
    if (!m_run) begin m_per = b_per; m_dut = b_dut; end
    else if (wrap) begin m_cnt = '0; m_per = b_per; m_dut = b_dut; m_sq = ~m_sq; end
    else if (tick) m_cnt = m_cnt + 1'b1;
    m_irqp = wrap;
    m_irqd = tick && (m_cnt == m_dut);
    if (wr_en) begin
      case (wr_addr)
        2'd0: b_per = wr_data;
        2'd1: b_dut = wr_data;
        2'd2: begin m_run = wr_data[0]; m_mode = wr_data[1]; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(count == m_cnt, "R2 count", count, m_cnt);
    check(irq_period == m_irqp, "R3 irq_period", W'(irq_period), W'(m_irqp));
    check(irq_duty == m_irqd, "R7 irq_duty", W'(irq_duty), W'(m_irqd));
    if (chk_wave) begin
      check(pin_oe == 1'b1, "R5 pin_oe", W'(pin_oe), W'(1));
      check(pin_out == exp_wave(), m_mode ? "R6 square" : "R5 pwm", W'(pin_out), W'(exp_wave()));
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1 reset state
    check(count == 0, "R1 count", count, 0);
    check(cap_value == 0, "R1 cap_value", cap_value, 0);
    check(pin_oe == 1'b1 && pin_out == 1'b0, "R1 pin", W'({pin_oe, pin_out}), W'(2'b10));
    check(!irq_period && !irq_duty, "R1 irqs", W'({irq_period, irq_duty}), 0);
    chk_wave = 1'b1;

    // R2 no counting while stopped
    cnt_en = 1'b1; idle(3);
    check(count == 0, "R2 stopped", count, 0);

    // R4 directed: reload waits for wrap
    wr(2'd0, 16'd10); wr(2'd1, 16'd4);
    wr(2'd2, ctrl_word(1, 0, 0, 0, 0));
    idle(3);
    wr(2'd0, 16'd4);
    while (m_cnt != 16'd6) cyc();
    check(count == 16'd6, "R4 count passes new period before wrap", count, 16'd6);
    while (m_cnt != 0) cyc();
    idle(5);
    check(count == 16'd0 && irq_period, "R4 new period 4 wraps", count, 16'd0);

    // R5 corners: duty 0 and duty above period
    wr(2'd1, 16'd0); idle(12);
    wr(2'd1, 16'd9); idle(12);
    // R3 period 0: wraps every tick
    wr(2'd0, 16'd0); idle(8);
    check(count == 0 && irq_period, "R3 period zero", count, 0);

    // random PWM and square stimulus
    for (int k = 0; k < 60; k++) begin
      wr(2'd0, W'($urandom_range(0, 20)));
      wr(2'd1, W'($urandom_range(0, 22)));
      if (k % 10 == 0)
        wr(2'd2, ctrl_word(1, (k / 10) % 2, 0, 0, 0));
      for (int j = 0; j < 40; j++) begin
        cnt_en = ($urandom_range(0, 3) != 0);
        cyc();
      end
    end

    // R8 capture
    wr(2'd0, 16'd200); wr(2'd2, ctrl_word(1, 0, 2'b01, 0, 0));
    cnt_en = 1'b1; idle(30); cnt_en = 1'b0; idle(1);
    cap_in = 1'b1; idle(4);
    check(cap_value == m_cnt, "R8 rising capture", cap_value, m_cnt);
    snap = cap_value;
    cnt_en = 1'b1; idle(7); cnt_en = 1'b0; idle(1);
    cap_in = 1'b0; idle(4);
    check(cap_value == snap, "R8 falling ignored", cap_value, snap);
    wr(2'd2, ctrl_word(1, 0, 2'b11, 0, 0));
    cnt_en = 1'b1; idle(5); cnt_en = 1'b0; idle(1);
    cap_in = 1'b1; idle(4);
    check(cap_value == m_cnt, "R8 both-edge capture", cap_value, m_cnt);
    cnt_en = 1'b1;

    // R11 disarmed trigger and wrong polarity ignored
    trig_in = 1'b1; idle(4);
    wr(2'd2, ctrl_word(1, 0, 0, 0, 2'b01)); idle(3);
    check(pin_oe && pin_out == exp_wave(), "R11 disarmed edge ignored", W'(pin_out), W'(exp_wave()));
    trig_in = 1'b0; idle(4);
    check(pin_oe && pin_out == exp_wave(), "R11 wrong polarity ignored", W'(pin_out), W'(exp_wave()));

    // R9 override high, low, hi-z
    trig_in = 1'b1; idle(1);
    check(pin_oe && pin_out == exp_wave(), "R9 not yet in force", W'(pin_out), W'(exp_wave()));
    chk_wave = 1'b0;
    idle(3);
    check(pin_oe && pin_out, "R9 forced high", W'({pin_oe, pin_out}), W'(2'b11));
    wr(2'd2, ctrl_word(1, 0, 0, 0, 2'b10)); idle(1);
    check(pin_oe && !pin_out, "R9 forced low", W'({pin_oe, pin_out}), W'(2'b10));
    wr(2'd2, ctrl_word(1, 0, 0, 0, 2'b11)); idle(1);
    check(!pin_oe && !pin_out, "R9 hi-z", W'({pin_oe, pin_out}), W'(2'b00));
    idle(20);
    check(!pin_oe, "R9 override persists", W'(pin_oe), 0);

    // R10 clear
    wr(2'd2, ctrl_word(1, 0, 0, 1, 2'b00));
    check(pin_oe && pin_out == exp_wave(), "R10 released", W'(pin_out), W'(exp_wave()));
    chk_wave = 1'b1;
    wr(2'd2, ctrl_word(1, 0, 0, 1, 2'b11)); idle(4);
    check(pin_oe && pin_out == exp_wave(), "R10 stays released after rearm", W'(pin_out), W'(exp_wave()));

    // R11 falling polarity triggers
    trig_in = 1'b0; idle(1);
    chk_wave = 1'b0;
    idle(3);
    check(!pin_oe, "R11 falling trigger", W'(pin_oe), 0);
    wr(2'd2, ctrl_word(1, 1, 0, 1, 2'b00));
    chk_wave = 1'b1;
    idle(60);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule